// File: doc/BRIEF.md
# Dual-Width Barrel Shifter

This block is the shift unit of a 64-bit integer datapath. It moves a 64-bit operand left or right by an amount that comes either from a register value or from an instruction immediate. It can work on the full 64-bit word or on the low 32 bits only. In the 32-bit word mode the result is always sign-extended from bit 31 into the upper half. The unit takes one result register: inputs presented before a rising clock edge produce the result after that edge.

The decoder in front of the block chooses the shift kind, the word mode and the amount source. The shifter masks the amount to the width that suits the mode. It picks the fill bit, which is zero or a copy of the sign. For the immediate form it applies the arithmetic/logical choice carried in the immediate. It also raises a flag for encodings that are reserved or illegal. A flagged operation returns zero, so nothing from a reserved encoding can leak into the register file.

Top module: `dual_width_shifter`

## Requirements
- R1: Outputs are registered with a latency of one clock. A synchronous active-high reset clears `result` to zero and `rsvd` to 0.
- R2: In full-width mode the amount is the low 6 bits of `reg_amt` (register form) or `imm[5:0]` (immediate form). Higher bits of `reg_amt` have no effect.
- R3: In word mode with the register form the amount is `reg_amt[4:0]`. Bit 5 and above have no effect.
- R4: A left shift (`kind` 2'b00) puts zeros into the vacated low bits.
- R5: A logical right shift (`kind` 2'b01, register form) puts zeros into the vacated high bits of the shifted word.
- R6: An arithmetic right shift (`kind` 2'b11, register form) fills the vacated high bits with the sign bit of the shifted word. That sign bit is bit 63 in full-width mode.
- R7: In word mode only `operand[31:0]` is shifted, and the sign bit for an arithmetic shift is bit 31. The 32-bit result is sign-extended to 64 bits, so `operand[63:32]` has no effect.
- R8: A logical right word shift by zero still copies bit 31 of the operand into `result[63:32]`.
- R9: In the immediate form (`use_imm`=1), a right-shift kind (2'b01 or 2'b11) is arithmetic when `imm[10]` is 1 and logical when it is 0. A left shift ignores `imm[10]`.
- R10: An immediate word shift with `imm[5]`=1 is reserved. It sets `rsvd` and forces `result` to zero.
- R11: `kind` 2'b10 is illegal. It sets `rsvd` and forces `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| operand | input | 64 | Value to shift |
| reg_amt | input | 64 | Register value that supplies the amount in register form |
| imm | input | 12 | Immediate field: amount in [5:0], arithmetic select in [10] |
| kind | input | 2 | 00 left, 01 right logical, 11 right arithmetic, 10 illegal |
| word_mode | input | 1 | 1 selects the 32-bit word mode |
| use_imm | input | 1 | 1 takes the amount from `imm`, 0 from `reg_amt` |
| result | output | 64 | Registered shift result |
| rsvd | output | 1 | Registered reserved/illegal encoding flag |

## Verification
Reserved detection and the shift datapath are both active in the same cycle. The sharp case is an immediate word shift with `imm[5]` set, where the low amount bits and `imm[10]` would otherwise choose a real arithmetic shift of a negative operand. The bench drives exactly that combination, and it also drives an illegal kind with a large amount. In both cases it expects the flag together with an all-zero result and no trace of the shifted value. Sign extension in word mode also meets the zero-amount path: a logical right word shift by zero of an operand with bit 31 set must still fill the upper half with ones.

// File: rtl/dws_pkg.sv
package dws_pkg;

    localparam int XLEN          = 64;
    localparam int HALF          = XLEN / 2;
    localparam int AMT_W         = $clog2(XLEN);
    localparam int IMM_W         = 12;
    localparam int IMM_ARITH_BIT = 10;

    typedef enum logic [1:0] {
        SK_LEFT = 2'b00,
        SK_RLOG = 2'b01,
        SK_BAD  = 2'b10,
        SK_RARI = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic             left;
        logic             arith;
        logic             word;
        logic [AMT_W-1:0] amt;
        logic             rsvd;
    } shift_ctl_t;

    function automatic logic [XLEN-1:0] sext_half(input logic [HALF-1:0] v);
        return {{(XLEN-HALF){v[HALF-1]}}, v};
    endfunction

endpackage

// File: rtl/dws_ctl.sv
module dws_ctl
    import dws_pkg::*;
(
    input  logic [XLEN-1:0]  reg_amt,
    input  logic [IMM_W-1:0] imm,
    input  logic [1:0]       kind,
    input  logic             word_mode,
    input  logic             use_imm,
    output shift_ctl_t       ctl
);
    shift_kind_e      k;
    logic [AMT_W-1:0] raw;

    always_comb begin
        k   = shift_kind_e'(kind);
        raw = use_imm ? imm[AMT_W-1:0] : reg_amt[AMT_W-1:0];

        ctl.word = word_mode;
        ctl.left = (k == SK_LEFT);
        if (use_imm)
            ctl.arith = (k == SK_RLOG || k == SK_RARI) && imm[IMM_ARITH_BIT];
        else
            ctl.arith = (k == SK_RARI);

        // word shifts use one bit less of amount
        ctl.amt  = word_mode ? {1'b0, raw[AMT_W-2:0]} : raw;
        ctl.rsvd = (k == SK_BAD) || (use_imm && word_mode && imm[AMT_W-1]);
    end
endmodule

// File: rtl/dws_word_adapt.sv
module dws_word_adapt
    import dws_pkg::*;
#(
    parameter int DW = XLEN,
    parameter int HW = DW / 2
) (
    input  logic          word,
    input  logic          left,
    input  logic          arith,
    input  logic [DW-1:0] operand,
    input  logic [DW-1:0] shifted,
    output logic [DW-1:0] prepared,
    output logic          fill,
    output logic [DW-1:0] finished
);
    always_comb begin
        if (word) begin
            fill     = arith && !left && operand[HW-1];
            prepared = {{(DW-HW){fill}}, operand[HW-1:0]};
            finished = {{(DW-HW){shifted[HW-1]}}, shifted[HW-1:0]};
        end else begin
            fill     = arith && !left && operand[DW-1];
            prepared = operand;
            finished = shifted;
        end
    end
endmodule

// File: rtl/dws_barrel.sv
module dws_barrel #(
    parameter int DW = 64,
    parameter int SW = $clog2(DW)
) (
    input  logic [DW-1:0] data,
    input  logic [SW-1:0] amt,
    input  logic          left,
    input  logic          fill,
    output logic [DW-1:0] res
);
    logic [DW-1:0] rev_in;
    logic [DW-1:0] rev_out;
    logic [DW-1:0] stg [0:SW];
    logic          fill_eff;

    assign fill_eff = left ? 1'b0 : fill;

    for (genvar j = 0; j < DW; j++) begin : g_rev
        assign rev_in[j]  = data[DW-1-j];
        assign rev_out[j] = stg[SW][DW-1-j];
    end

    assign stg[0] = left ? rev_in : data;

    for (genvar i = 0; i < SW; i++) begin : g_stage
        localparam int STEP = 1 << i;
        assign stg[i+1] = amt[i] ? {{STEP{fill_eff}}, stg[i][DW-1:STEP]} : stg[i];
    end

    assign res = left ? rev_out : stg[SW];
endmodule

// File: rtl/dual_width_shifter.sv
module dual_width_shifter
    import dws_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [63:0]      operand,
    input  logic [63:0]      reg_amt,
    input  logic [11:0]      imm,
    input  logic [1:0]       kind,
    input  logic             word_mode,
    input  logic             use_imm,
    output logic [63:0]      result,
    output logic             rsvd
);
    shift_ctl_t    ctl;
    logic [63:0]   prepared;
    logic [63:0]   shifted;
    logic [63:0]   finished;
    logic          fill;

    dws_ctl u_ctl (
        .reg_amt  (reg_amt),
        .imm      (imm),
        .kind     (kind),
        .word_mode(word_mode),
        .use_imm  (use_imm),
        .ctl      (ctl)
    );

    dws_word_adapt #(.DW(XLEN)) u_adapt (
        .word    (ctl.word),
        .left    (ctl.left),
        .arith   (ctl.arith),
        .operand (operand),
        .shifted (shifted),
        .prepared(prepared),
        .fill    (fill),
        .finished(finished)
    );

    dws_barrel #(.DW(XLEN)) u_barrel (
        .data(prepared),
        .amt (ctl.amt),
        .left(ctl.left),
        .fill(fill),
        .res (shifted)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            rsvd   <= 1'b0;
        end else begin
            result <= ctl.rsvd ? '0 : finished;
            rsvd   <= ctl.rsvd;
        end
    end
endmodule

// File: rtl/dws_chk.sv
module dws_chk (
    input logic        clk,
    input logic        rst,
    input logic [63:0] operand,
    input logic [63:0] reg_amt,
    input logic [11:0] imm,
    input logic [1:0]  kind,
    input logic        word_mode,
    input logic        use_imm,
    input logic [63:0] result,
    input logic        rsvd
);
    logic [5:0]  full_amt;
    logic [63:0] low_mask;
    logic        bad_enc;

    assign full_amt = use_imm ? imm[5:0] : reg_amt[5:0];
    assign low_mask = (64'd1 << full_amt) - 64'd1;
    assign bad_enc  = (kind == 2'b10) || (use_imm && word_mode && imm[5]);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (result == 64'd0 && !rsvd));

    // R10
    imm_word_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
        (use_imm && word_mode && imm[5]) |=> rsvd);

    // R11
    bad_kind_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == 2'b10) |=> rsvd);

    // R10
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsvd |-> (result == 64'd0));

    // R7
    word_sext_chk: assert property (@(posedge clk) disable iff (rst)
        (word_mode && !bad_enc) |=> (result[63:32] == {32{result[31]}}));

    // R4
    left_zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == 2'b00 && !word_mode) |=> ((result & $past(low_mask)) == 64'd0));

    // R8
    word_zero_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (word_mode && !use_imm && kind == 2'b01 && reg_amt[4:0] == 5'd0)
        |=> (result == {{32{$past(operand[31])}}, $past(operand[31:0])}));
endmodule

bind dual_width_shifter dws_chk u_chk (.*);

// File: tb/tb_dual_width_shifter.sv
`timescale 1ns/1ps
module tb_dual_width_shifter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] operand = '0;
    logic [63:0] reg_amt = '0;
    logic [11:0] imm = '0;
    logic [1:0]  kind = '0;
    logic        word_mode = 1'b0;
    logic        use_imm = 1'b0;
    logic [63:0] result;
    logic        rsvd;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dual_width_shifter dut (
        .clk(clk), .rst(rst), .operand(operand), .reg_amt(reg_amt), .imm(imm),
        .kind(kind), .word_mode(word_mode), .use_imm(use_imm),
        .result(result), .rsvd(rsvd)
    );

    function automatic logic [64:0] model(input logic [63:0] op, input logic [63:0] ra,
                                          input logic [11:0] im, input logic [1:0] k,
                                          input logic w, input logic ui);
        logic [5:0]  a;
        logic        ar;
        logic [31:0] r32;
        logic [63:0] r64;
        if (k == 2'b10 || (ui && w && im[5])) return {1'b1, 64'd0};
        a  = ui ? im[5:0] : ra[5:0];
        if (w) a[5] = 1'b0;
        ar = ui ? im[10] : (k == 2'b11);
        if (w) begin
            if (k == 2'b00)  r32 = op[31:0] << a;
            else if (ar)     r32 = 32'($signed(op[31:0]) >>> a);
            else             r32 = op[31:0] >> a;
            return {1'b0, {32{r32[31]}}, r32};
        end
        if (k == 2'b00)  r64 = op << a;
        else if (ar)     r64 = 64'($signed(op) >>> a);
        else             r64 = op >> a;
        return {1'b0, r64};
    endfunction

    task automatic compare(input string tag, input logic [64:0] exp);
        checks++;
        if ({rsvd, result} !== exp) begin
            failures++;
            $display("FAIL %s actual rsvd=%0b result=%h expected rsvd=%0b result=%h",
                     tag, rsvd, result, exp[64], exp[63:0]);
        end
    endtask

    task automatic run(input string tag, input logic [63:0] op, input logic [63:0] ra,
                       input logic [11:0] im, input logic [1:0] k, input logic w,
                       input logic ui);
        operand = op; reg_amt = ra; imm = im; kind = k; word_mode = w; use_imm = ui;
        @(negedge clk);
        compare(tag, model(op, ra, im, k, w, ui));
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        string tag;
        logic [63:0] op, ra;
        logic [11:0] im;
        logic [1:0]  k;
        logic        w, ui;
        void'($urandom(32'd2468));
        repeat (3) @(negedge clk);
        operand = 64'hFFFF_FFFF_FFFF_FFFF;
        // R1 reset state
        compare("R1 reset", {1'b0, 64'd0});
        rst = 1'b0;
        @(negedge clk);

        // R2 high register amount bits ignored
        run("R2", 64'h0000_0000_0000_00F1, 64'hFFFF_FFFF_FFFF_FFC4, 12'h0, 2'b00, 1'b0, 1'b0);
        run("R2 imm", 64'h1234_5678_9ABC_DEF0, 64'h0, 12'h03F, 2'b01, 1'b0, 1'b1);
        // R3 word register amount takes bits 4:0
        run("R3", 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0025, 12'h0, 2'b00, 1'b1, 1'b0);
        // R4 left zero fill
        run("R4", 64'hFFFF_FFFF_FFFF_FFFF, 64'd13, 12'h0, 2'b00, 1'b0, 1'b0);
        // R5 right logical zero fill
        run("R5", 64'h8000_0000_0000_0001, 64'd63, 12'h0, 2'b01, 1'b0, 1'b0);
        // R6 right arithmetic sign fill
        run("R6", 64'h8000_0000_0000_0000, 64'd63, 12'h0, 2'b11, 1'b0, 1'b0);
        // R7 word arithmetic uses bit 31, upper input ignored
        run("R7", 64'h7FFF_FFFF_8000_0000, 64'd4, 12'h0, 2'b11, 1'b1, 1'b0);
        run("R7 left", 64'hAAAA_AAAA_4000_0001, 64'd1, 12'h0, 2'b00, 1'b1, 1'b0);
        // R8 logical word shift by zero still sign extends
        run("R8", 64'h0000_0000_8765_4321, 64'h20, 12'h0, 2'b01, 1'b1, 1'b0);
        // R9 immediate bit 10 selects arithmetic
        run("R9 arith", 64'hF000_0000_0000_0000, 64'h0, 12'h404, 2'b01, 1'b0, 1'b1);
        run("R9 logic", 64'hF000_0000_0000_0000, 64'h0, 12'h004, 2'b11, 1'b0, 1'b1);
        run("R9 left", 64'h0000_0000_0000_0001, 64'h0, 12'h405, 2'b00, 1'b0, 1'b1);
        // R10 reserved immediate word shift collides with arithmetic shift
        run("R10", 64'hFFFF_FFFF_8000_0000, 64'h0, 12'h423, 2'b11, 1'b1, 1'b1);
        // R11 illegal kind
        run("R11", 64'hDEAD_BEEF_DEAD_BEEF, 64'd7, 12'h0, 2'b10, 1'b0, 1'b0);
        // R1 recovery after flag, then mid-run reset
        run("R1 after", 64'h1, 64'd1, 12'h0, 2'b00, 1'b0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        compare("R1 mid reset", {1'b0, 64'd0});
        rst = 1'b0;

        for (int n = 0; n < 400; n++) begin
            op = {$urandom, $urandom};
            ra = {$urandom, $urandom};
            im = 12'($urandom);
            k  = 2'($urandom);
            w  = 1'($urandom);
            ui = 1'($urandom);
            if (k == 2'b10 && ($urandom % 4) != 0) k = 2'b11;
            if (k == 2'b10)              tag = "R11 rnd";
            else if (ui && w && im[5])   tag = "R10 rnd";
            else if (w)                  tag = "R7 rnd";
            else if (ui)                 tag = "R9 rnd";
            else if (k == 2'b00)         tag = "R4 rnd";
            else if (k == 2'b11)         tag = "R6 rnd";
            else                         tag = "R5 rnd";
            run(tag, op, ra, im, k, w, ui);
        end

        finished = 1'b1;
        finish_run();
    end
endmodule